// File: doc/BRIEF.md
# MSI Write-Back Snooping Cache Controller

This block is the coherence controller for one private cache on an atomic snooping bus. It keeps a small direct-mapped array of one-word lines. Each line holds a tag, a data word and one of three states. In Modified, this cache has the only valid copy and memory is stale. In Shared, the copy is valid here and in memory, and memory is the owner. In Invalid, only memory holds a valid value. The processor side issues loads, stores and explicit evictions. The controller turns each of these into a local hit or into one bus transaction. GETS fetches a line for reading. GETX fetches a line with intent to modify and invalidates all other copies. PUTX writes a dirty line back to memory.

Every request from another cache is presented on the snoop port. The controller reacts in the same cycle. When it holds the addressed line in Modified, it raises an owner flag so that memory stays silent, and it drives the line data for a cache-to-cache transfer. A remote read demotes the line to Shared. A remote exclusive request invalidates the line. Remote writebacks never change anything here. A load or store that hits a line whose tag differs and whose state is Modified first writes that victim back with PUTX. It then issues its own fetch.

The bus is atomic: once `busGnt` is seen with `busReq`, the transaction completes in that cycle. The requesting processor keeps `cpuReq` high until `cpuDone` pulses.

Top module: `msi_snoop_cache`

## Requirements
- R1: After reset every line is Invalid. `busReq` and `cpuDone` are low, and no snoop raises `snpOwner`.
- R2: A load to a line in Invalid issues exactly one GETS (busCmd=1) for the load address. It returns `busRdata` on `cpuRdata` and leaves the line Shared.
- R3: A load to a line in Shared or Modified with a matching tag completes with no bus transaction and returns the stored word.
- R4: A store to a line in Invalid or Shared issues exactly one GETX (busCmd=2) and leaves the line Modified with the store data. A store to a Modified line completes with no bus transaction.
- R5: A snooped GETS (snpCmd=1) to a Modified line raises `snpOwner` in the same cycle, drives the line data on `snpData`, and demotes the line to Shared. A later store then needs a GETX.
- R6: A snooped GETX (snpCmd=2) to a Shared or Modified line invalidates it, and a later load issues GETS. If the line was Modified, the cache also raises `snpOwner` and supplies the data.
- R7: Evicting (cpuOp=2) a Modified line issues one PUTX (busCmd=3) carrying the line address and data, and leaves the line Invalid. Evicting a Shared line drops it silently. Evicting an Invalid line does nothing.
- R8: A snooped PUTX (snpCmd=3) never raises `snpOwner` and leaves the line state unchanged.
- R9: A snoop whose tag does not match the stored line, or that finds the line Shared or Invalid, does not raise `snpOwner`.
- R10: A load or store whose index holds a Modified line with another tag first issues PUTX for the victim's address and data. It then issues its own GETS or GETX.
- R11: A load followed by a store to an Invalid line produces exactly two bus transactions, GETS and then GETX.
- R12: While a request waits for grant, `busReq`, `busCmd` and `busAddr` stay stable. `cpuDone` rises for exactly one cycle, in the cycle after the grant that finishes the operation. Processor op encoding: load=0, store=1, evict=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor request, held until cpuDone |
| cpuOp | input | 2 | 0 load, 1 store, 2 evict |
| cpuAddr | input | ADDR_W | Processor word address |
| cpuWdata | input | DATA_W | Store data |
| cpuDone | output | 1 | One-cycle completion pulse |
| cpuRdata | output | DATA_W | Load result, valid with cpuDone |
| busReq | output | 1 | Bus transaction request |
| busCmd | output | 2 | 0 none, 1 GETS, 2 GETX, 3 PUTX |
| busAddr | output | ADDR_W | Transaction address |
| busWdata | output | DATA_W | Writeback data for PUTX |
| busGnt | input | 1 | Grant; the transaction completes this cycle |
| busRdata | input | DATA_W | Fill data for GETS/GETX, valid with grant |
| snpValid | input | 1 | Remote request present on the bus |
| snpCmd | input | 2 | Remote command, same encoding as busCmd |
| snpAddr | input | ADDR_W | Remote request address |
| snpOwner | output | 1 | This cache supplies the data; memory stays silent |
| snpData | output | DATA_W | Supplied data, valid with snpOwner |

## Verification
A wrong line state becomes visible at the ports as soon as the next operation touches that line. A line wrongly left Modified raises `snpOwner` on the next snooped read. A line wrongly left Shared or Invalid shows up as an extra GETX or GETS on the next store or load. Each scenario therefore follows its state change with a probe operation: a load, a store or a snoop. The probe's bus traffic and owner response show the state within one transaction. Victim writeback ordering and grant delays are checked through the order and content of the logged bus commands.

// File: rtl/msi_cache_pkg.sv
package msi_cache_pkg;
  typedef enum logic [1:0] {
    LINE_I = 2'd0,
    LINE_S = 2'd1,
    LINE_M = 2'd2
  } line_state_e;

  typedef enum logic [1:0] {
    BUS_NONE = 2'd0,
    BUS_GETS = 2'd1,
    BUS_GETX = 2'd2,
    BUS_PUTX = 2'd3
  } bus_cmd_e;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_EVICT = 2'd2
  } cpu_op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic        lineWr;
    line_state_e lineNext;
    logic        tagWr;
    logic        dataFromBus;
    logic        dataFromCpu;
    logic        rdFromBus;
    logic        rdFromLine;
    logic        snpWr;
    line_state_e snpNext;
  } ctrl_t;
endpackage

// File: rtl/msi_cache_dp.sv
module msi_cache_dp
  import msi_cache_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] busRdata,
  input  logic [ADDR_W-1:0] snpAddr,
  output line_state_e       lineState,
  output logic              lineTagHit,
  output logic [ADDR_W-1:0] victimAddr,
  output logic [DATA_W-1:0] lineData,
  output line_state_e       snpState,
  output logic              snpTagHit,
  output logic [DATA_W-1:0] snpLineData,
  output logic              idxClash,
  output logic [DATA_W-1:0] cpuRdata
);
  localparam int IDX_W = $clog2(NUM_LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  line_state_e       stArr   [NUM_LINES];
  logic [TAG_W-1:0]  tagArr  [NUM_LINES];
  logic [DATA_W-1:0] dataArr [NUM_LINES];

  logic [IDX_W-1:0] cpuIdx, snpIdx;
  logic [TAG_W-1:0] cpuTag, snpTag;

  assign cpuIdx = cpuAddr[IDX_W-1:0];
  assign cpuTag = cpuAddr[ADDR_W-1:IDX_W];
  assign snpIdx = snpAddr[IDX_W-1:0];
  assign snpTag = snpAddr[ADDR_W-1:IDX_W];

  assign lineState   = stArr[cpuIdx];
  assign lineTagHit  = tagArr[cpuIdx] == cpuTag;
  assign victimAddr  = {tagArr[cpuIdx], cpuIdx};
  assign lineData    = dataArr[cpuIdx];
  assign snpState    = stArr[snpIdx];
  assign snpTagHit   = tagArr[snpIdx] == snpTag;
  assign snpLineData = dataArr[snpIdx];
  assign idxClash    = cpuIdx == snpIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_LINES; i++) stArr[i] <= LINE_I;
    end else begin
      if (ctrl.lineWr) stArr[cpuIdx] <= ctrl.lineNext;
      if (ctrl.snpWr)  stArr[snpIdx] <= ctrl.snpNext;
    end
  end

  always_ff @(posedge clk) begin
    if (ctrl.tagWr) tagArr[cpuIdx] <= cpuTag;
    if (ctrl.dataFromCpu)      dataArr[cpuIdx] <= cpuWdata;
    else if (ctrl.dataFromBus) dataArr[cpuIdx] <= busRdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                cpuRdata <= '0;
    else if (ctrl.rdFromBus)  cpuRdata <= busRdata;
    else if (ctrl.rdFromLine) cpuRdata <= dataArr[cpuIdx];
  end
endmodule

// File: rtl/msi_cache_ctrl.sv
module msi_cache_ctrl
  import msi_cache_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuReq,
  input  logic [1:0]  cpuOp,
  input  logic        busGnt,
  input  logic        snpValid,
  input  logic [1:0]  snpCmd,
  input  line_state_e lineState,
  input  logic        lineTagHit,
  input  line_state_e snpState,
  input  logic        snpTagHit,
  input  logic        idxClash,
  output ctrl_t       ctrl,
  output logic        busReq,
  output logic [1:0]  busCmd,
  output logic        useVictim,
  output logic        snpOwner,
  output logic        cpuDone
);
  typedef enum logic {ST_ACT, ST_RESP} fsm_e;
  fsm_e fsm, fsmNext;

  cpu_op_e  opC;
  bus_cmd_e cmd, snpC;
  logic     present, victimDirty, snpHit;

  assign opC  = cpu_op_e'(cpuOp);
  assign snpC = bus_cmd_e'(snpCmd);

  always_comb begin
    ctrl        = '0;
    cmd         = BUS_NONE;
    useVictim   = 1'b0;
    fsmNext     = fsm;
    present     = (lineState != LINE_I) && lineTagHit;
    victimDirty = (lineState == LINE_M) && !lineTagHit;

    // snoop side: reacts every cycle
    snpHit   = snpValid && (snpState != LINE_I) && snpTagHit;
    snpOwner = snpHit && (snpState == LINE_M) &&
               (snpC == BUS_GETS || snpC == BUS_GETX);
    if (snpHit && snpC == BUS_GETS && snpState == LINE_M) begin
      ctrl.snpWr   = 1'b1;
      ctrl.snpNext = LINE_S;
    end
    if (snpHit && snpC == BUS_GETX) begin
      ctrl.snpWr   = 1'b1;
      ctrl.snpNext = LINE_I;
    end

    // processor side
    if (fsm == ST_ACT && cpuReq) begin
      case (opC)
        OP_LOAD: begin
          if (victimDirty) begin cmd = BUS_PUTX; useVictim = 1'b1; end
          else if (!present) cmd = BUS_GETS;
        end
        OP_STORE: begin
          if (victimDirty) begin cmd = BUS_PUTX; useVictim = 1'b1; end
          else if (!(present && lineState == LINE_M)) cmd = BUS_GETX;
        end
        OP_EVICT: begin
          if (present && lineState == LINE_M) cmd = BUS_PUTX;
        end
        default: cmd = BUS_NONE;
      endcase

      if (cmd != BUS_NONE) begin
        if (busGnt) begin
          case (cmd)
            BUS_PUTX: begin
              ctrl.lineWr   = 1'b1;
              ctrl.lineNext = LINE_I;
              if (!useVictim) fsmNext = ST_RESP;
            end
            BUS_GETS: begin
              ctrl.lineWr      = 1'b1;
              ctrl.lineNext    = LINE_S;
              ctrl.tagWr       = 1'b1;
              ctrl.dataFromBus = 1'b1;
              ctrl.rdFromBus   = 1'b1;
              fsmNext          = ST_RESP;
            end
            default: begin
              ctrl.lineWr      = 1'b1;
              ctrl.lineNext    = LINE_M;
              ctrl.tagWr       = 1'b1;
              ctrl.dataFromCpu = 1'b1;
              fsmNext          = ST_RESP;
            end
          endcase
        end
      end else if (!(snpValid && idxClash)) begin
        case (opC)
          OP_LOAD:  ctrl.rdFromLine  = 1'b1;
          OP_STORE: ctrl.dataFromCpu = 1'b1;
          OP_EVICT: if (present) begin
            ctrl.lineWr   = 1'b1;
            ctrl.lineNext = LINE_I;
          end
          default: ;
        endcase
        fsmNext = ST_RESP;
      end
    end else if (fsm == ST_RESP) begin
      fsmNext = ST_ACT;
    end
  end

  assign busReq  = cmd != BUS_NONE;
  assign busCmd  = cmd;
  assign cpuDone = fsm == ST_RESP;

  always_ff @(posedge clk) begin
    if (!rstN) fsm <= ST_ACT;
    else       fsm <= fsmNext;
  end
endmodule

// File: rtl/msi_snoop_cache.sv
module msi_snoop_cache
  import msi_cache_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic [1:0]        cpuOp,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuDone,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              busReq,
  output logic [1:0]        busCmd,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic              busGnt,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              snpValid,
  input  logic [1:0]        snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              snpOwner,
  output logic [DATA_W-1:0] snpData
);
  ctrl_t             ctrl;
  line_state_e       lineState, snpState;
  logic              lineTagHit, snpTagHit, idxClash, useVictim;
  logic [ADDR_W-1:0] victimAddr;
  logic [DATA_W-1:0] lineData;

  msi_cache_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuOp(cpuOp),
    .busGnt(busGnt), .snpValid(snpValid), .snpCmd(snpCmd),
    .lineState(lineState), .lineTagHit(lineTagHit),
    .snpState(snpState), .snpTagHit(snpTagHit), .idxClash(idxClash),
    .ctrl(ctrl), .busReq(busReq), .busCmd(busCmd), .useVictim(useVictim),
    .snpOwner(snpOwner), .cpuDone(cpuDone)
  );

  msi_cache_dp #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .busRdata(busRdata), .snpAddr(snpAddr),
    .lineState(lineState), .lineTagHit(lineTagHit), .victimAddr(victimAddr),
    .lineData(lineData), .snpState(snpState), .snpTagHit(snpTagHit),
    .snpLineData(snpData), .idxClash(idxClash), .cpuRdata(cpuRdata)
  );

  assign busAddr  = useVictim ? victimAddr : cpuAddr;
  assign busWdata = lineData;
endmodule

// File: rtl/msi_snoop_cache_chk.sv
module msi_snoop_cache_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReq,
  input logic              cpuDone,
  input logic              busReq,
  input logic [1:0]        busCmd,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busGnt,
  input logic              snpValid,
  input logic [1:0]        snpCmd,
  input logic [ADDR_W-1:0] snpAddr,
  input logic              snpOwner
);
  AST_IDLE_NO_BUS: assert property (@(posedge clk) disable iff (!rstN)
    !cpuReq |-> !busReq);  // R1

  AST_CMD_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> busCmd != 2'd0);  // R12

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busGnt && !snpValid |=> busReq && $stable(busCmd) && $stable(busAddr));  // R12

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |=> !cpuDone);  // R12

  AST_FETCH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busGnt && (busCmd == 2'd1 || busCmd == 2'd2) |=> cpuDone);  // R2

  AST_OWNER_SNOOP: assert property (@(posedge clk) disable iff (!rstN)
    snpOwner |-> snpValid && snpCmd != 2'd3 && snpCmd != 2'd0);  // R8

  AST_DEMOTE_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    snpValid && snpOwner |=> !(snpValid && snpOwner && snpAddr == $past(snpAddr)));  // R5
endmodule

bind msi_snoop_cache msi_snoop_cache_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuDone(cpuDone),
  .busReq(busReq), .busCmd(busCmd), .busAddr(busAddr), .busGnt(busGnt),
  .snpValid(snpValid), .snpCmd(snpCmd), .snpAddr(snpAddr), .snpOwner(snpOwner)
);

// File: tb/tb_msi_snoop_cache.sv
module tb_msi_snoop_cache;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cpuReq = 1'b0;
  logic [1:0]        cpuOp = 2'd0;
  logic [ADDR_W-1:0] cpuAddr = '0;
  logic [DATA_W-1:0] cpuWdata = '0;
  logic              cpuDone;
  logic [DATA_W-1:0] cpuRdata;
  logic              busReq;
  logic [1:0]        busCmd;
  logic [ADDR_W-1:0] busAddr;
  logic [DATA_W-1:0] busWdata;
  logic              busGnt = 1'b0;
  logic [DATA_W-1:0] busRdata = '0;
  logic              snpValid = 1'b0;
  logic [1:0]        snpCmd = 2'd0;
  logic [ADDR_W-1:0] snpAddr = '0;
  logic              snpOwner;
  logic [DATA_W-1:0] snpData;

  int checks = 0;
  int errors = 0;

  logic [DATA_W-1:0] mem [256];
  int                txCount;
  logic [1:0]        txCmd  [8];
  logic [ADDR_W-1:0] txAddr [8];
  logic [DATA_W-1:0] txData [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_snoop_cache dut (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuOp(cpuOp), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuDone(cpuDone), .cpuRdata(cpuRdata),
    .busReq(busReq), .busCmd(busCmd), .busAddr(busAddr), .busWdata(busWdata),
    .busGnt(busGnt), .busRdata(busRdata), .snpValid(snpValid), .snpCmd(snpCmd),
    .snpAddr(snpAddr), .snpOwner(snpOwner), .snpData(snpData)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // one processor operation with a simple bus model; grant after grantDelay waiting cycles
  task automatic doOp(input logic [1:0] op, input logic [ADDR_W-1:0] addr,
                      input logic [DATA_W-1:0] wdata, input int grantDelay,
                      output logic [DATA_W-1:0] rdata);
    int cycles = 0;
    int waitCnt = 0;
    int gntCycle = -10;
    bit done = 0;
    logic [1:0] holdCmd = 2'd0;
    logic [ADDR_W-1:0] holdAddr = '0;
    txCount = 0;
    rdata = '0;
    @(negedge clk);
    cpuReq = 1'b1; cpuOp = op; cpuAddr = addr; cpuWdata = wdata;
    while (!done && cycles < 60) begin
      #1;
      if (cpuDone) begin
        rdata = cpuRdata;
        done = 1;
        if (grantDelay > 0)
          chk(cycles == gntCycle + 1, "R12", "done cycle after grant", cycles, gntCycle + 1);
      end else if (busReq) begin
        if (grantDelay > 0 && waitCnt > 0) begin
          chk(busCmd == holdCmd, "R12", "cmd held while waiting", busCmd, holdCmd);
          chk(busAddr == holdAddr, "R12", "addr held while waiting", busAddr, holdAddr);
        end
        holdCmd = busCmd; holdAddr = busAddr;
        if (waitCnt < grantDelay) waitCnt++;
        else begin
          if (txCount < 8) begin
            txCmd[txCount] = busCmd; txAddr[txCount] = busAddr; txData[txCount] = busWdata;
          end
          txCount++;
          busGnt = 1'b1;
          busRdata = mem[busAddr];
          if (busCmd == 2'd3) mem[busAddr] = busWdata;
          waitCnt = 0;
          gntCycle = cycles;
        end
      end
      if (!done) begin
        @(negedge clk);
        busGnt = 1'b0;
        cycles++;
      end
    end
    if (!done) chk(0, "R12", "operation never completed", cycles, 0);
    cpuReq = 1'b0;
  endtask

  task automatic snoop(input logic [1:0] cmd, input logic [ADDR_W-1:0] addr,
                       output logic own, output logic [DATA_W-1:0] data);
    @(negedge clk);
    snpValid = 1'b1; snpCmd = cmd; snpAddr = addr;
    #1;
    own = snpOwner; data = snpData;
    @(posedge clk); #1;
    snpValid = 1'b0; snpCmd = 2'd0;
  endtask

  task automatic testReset();
    logic own; logic [DATA_W-1:0] d;
    chk(busReq == 1'b0, "R1", "busReq after reset", busReq, 0);
    chk(cpuDone == 1'b0, "R1", "cpuDone after reset", cpuDone, 0);
    snoop(2'd1, 8'h11, own, d);
    chk(own == 1'b0, "R1", "owner after reset", own, 0);
  endtask

  task automatic testLoadMissHit();
    logic [DATA_W-1:0] r;
    doOp(2'd0, 8'h11, 0, 0, r);
    chk(txCount == 1 && txCmd[0] == 2'd1, "R2", "load miss GETS", txCmd[0], 1);
    chk(txAddr[0] == 8'h11, "R2", "GETS address", txAddr[0], 8'h11);
    chk(r == mem[8'h11], "R2", "load miss data", r, mem[8'h11]);
    doOp(2'd0, 8'h11, 0, 0, r);
    chk(txCount == 0, "R3", "load hit in S no bus", txCount, 0);
    chk(r == mem[8'h11], "R3", "load hit data", r, mem[8'h11]);
  endtask

  task automatic testStore();
    logic [DATA_W-1:0] r;
    doOp(2'd1, 8'h11, 16'hBEEF, 0, r);
    chk(txCount == 1 && txCmd[0] == 2'd2, "R4", "store in S issues GETX", txCmd[0], 2);
    doOp(2'd1, 8'h11, 16'hCAFE, 0, r);
    chk(txCount == 0, "R4", "store in M silent", txCount, 0);
    doOp(2'd0, 8'h11, 0, 0, r);
    chk(txCount == 0, "R3", "load hit in M no bus", txCount, 0);
    chk(r == 16'hCAFE, "R3", "load hit in M data", r, 16'hCAFE);
  endtask

  task automatic testRemoteRead();
    logic own; logic [DATA_W-1:0] d, r;
    snoop(2'd3, 8'h11, own, d);
    chk(own == 1'b0, "R8", "remote PUTX no owner", own, 0);
    snoop(2'd1, 8'h11, own, d);
    chk(own == 1'b1, "R8", "M kept after remote PUTX", own, 1);
    chk(d == 16'hCAFE, "R5", "supplied data", d, 16'hCAFE);
    snoop(2'd1, 8'h11, own, d);
    chk(own == 1'b0, "R5", "demoted to S no owner", own, 0);
    doOp(2'd0, 8'h11, 0, 0, r);
    chk(txCount == 0 && r == 16'hCAFE, "R5", "load hit after demote", r, 16'hCAFE);
    doOp(2'd1, 8'h11, 16'h1234, 0, r);
    chk(txCount == 1 && txCmd[0] == 2'd2, "R5", "store after demote GETX", txCmd[0], 2);
  endtask

  task automatic testRemoteWrite();
    logic own; logic [DATA_W-1:0] d, r;
    snoop(2'd2, 8'h11, own, d);
    chk(own == 1'b1 && d == 16'h1234, "R6", "GETX on M supplies data", d, 16'h1234);
    doOp(2'd0, 8'h11, 0, 0, r);
    chk(txCount == 1 && txCmd[0] == 2'd1, "R6", "load after invalidate GETS", txCmd[0], 1);
    snoop(2'd2, 8'h11, own, d);
    chk(own == 1'b0, "R6", "GETX on S no owner", own, 0);
    doOp(2'd0, 8'h11, 0, 0, r);
    chk(txCount == 1 && txCmd[0] == 2'd1, "R6", "S invalidated load GETS", txCmd[0], 1);
  endtask

  task automatic testTagMismatch();
    logic own; logic [DATA_W-1:0] d, r;
    doOp(2'd1, 8'h11, 16'h5555, 0, r);
    snoop(2'd1, 8'h19, own, d);
    chk(own == 1'b0, "R9", "GETS other tag no owner", own, 0);
    snoop(2'd2, 8'h19, own, d);
    chk(own == 1'b0, "R9", "GETX other tag no owner", own, 0);
    snoop(2'd1, 8'h11, own, d);
    chk(own == 1'b1 && d == 16'h5555, "R9", "line untouched by other tag", d, 16'h5555);
  endtask

  task automatic testEvict();
    logic [DATA_W-1:0] r;
    doOp(2'd1, 8'h22, 16'h7777, 0, r);
    doOp(2'd2, 8'h22, 0, 0, r);
    chk(txCount == 1 && txCmd[0] == 2'd3, "R7", "evict M PUTX", txCmd[0], 3);
    chk(txAddr[0] == 8'h22 && txData[0] == 16'h7777, "R7", "PUTX data", txData[0], 16'h7777);
    doOp(2'd2, 8'h22, 0, 0, r);
    chk(txCount == 0, "R7", "evict I nothing", txCount, 0);
    doOp(2'd0, 8'h22, 0, 0, r);
    chk(txCount == 1 && r == 16'h7777, "R7", "refetch written-back data", r, 16'h7777);
    doOp(2'd2, 8'h22, 0, 0, r);
    chk(txCount == 0, "R7", "evict S silent", txCount, 0);
    doOp(2'd0, 8'h22, 0, 0, r);
    chk(txCount == 1 && txCmd[0] == 2'd1, "R7", "S evicted load GETS", txCmd[0], 1);
  endtask

  task automatic testVictim();
    logic [DATA_W-1:0] r;
    doOp(2'd1, 8'h33, 16'hAAAA, 0, r);
    doOp(2'd0, 8'h3B, 0, 0, r);
    chk(txCount == 2, "R10", "victim plus fetch count", txCount, 2);
    chk(txCmd[0] == 2'd3 && txAddr[0] == 8'h33, "R10", "victim PUTX addr", txAddr[0], 8'h33);
    chk(txData[0] == 16'hAAAA, "R10", "victim PUTX data", txData[0], 16'hAAAA);
    chk(txCmd[1] == 2'd1 && txAddr[1] == 8'h3B, "R10", "then GETS new addr", txAddr[1], 8'h3B);
    chk(r == mem[8'h3B], "R10", "new line data", r, mem[8'h3B]);
  endtask

  task automatic testReadThenWrite();
    logic [DATA_W-1:0] r;
    int total;
    logic [1:0] first;
    doOp(2'd0, 8'h44, 0, 0, r);
    total = txCount; first = txCmd[0];
    doOp(2'd1, 8'h44, 16'h0F0F, 0, r);
    total += txCount;
    chk(total == 2, "R11", "read then write transactions", total, 2);
    chk(first == 2'd1 && txCmd[0] == 2'd2, "R11", "GETS then GETX", txCmd[0], 2);
  endtask

  task automatic testGrantDelay();
    logic [DATA_W-1:0] r;
    doOp(2'd0, 8'h55, 0, 3, r);
    chk(txCount == 1 && r == mem[8'h55], "R12", "delayed grant load", r, mem[8'h55]);
    doOp(2'd1, 8'h55, 16'h9999, 2, r);
    chk(txCount == 1 && txCmd[0] == 2'd2, "R12", "delayed grant store", txCmd[0], 2);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h1000 + 16'(i * 7);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    testReset();
    testLoadMissHit();
    testStore();
    testRemoteRead();
    testRemoteWrite();
    testTagMismatch();
    testEvict();
    testVictim();
    testReadThenWrite();
    testGrantDelay();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R12 watchdog expired: actual 0x1 expected 0x0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule